// File: doc/BRIEF.md
# SD Command Issue and Inhibit Controller

This block is the command-path front end of an SD-style host controller. Software loads a 32-bit argument, a transfer-mode word and a command word through a small register write port. A write to the command word starts a command, but only if the inhibit flags allow it. An accepted command becomes a frame request (index plus argument) toward a line serializer, using a valid/ready handshake. The block then waits for the response, stores it, and reports the outcome through write-1-to-clear status bits.

The two-bit response kind in the command word sets how the command ends. Kind 00 has no response and completes when the serializer takes the frame. Kind 01 is a 136-bit response. Kind 10 is a 48-bit response. Kind 11 is a 48-bit response followed by a busy phase, during which DAT[0] is held low.

Two present-state flags guard issue. One guards the CMD line. The other guards the DAT line, for commands that carry data or signal busy. A response that does not arrive within a counted number of response-clock ticks ends the command with a timeout.

Top module: `sdc_cmd_issue`

## Requirements
- R1: After reset, present state and status read zero (apart from present bit 20, which follows `dat0`), `frm_valid` is low and the stored response is zero.
- R2: A command word holds the index in bits [13:8], data-present in bit 5, index-check enable in bit 4, CRC-check enable in bit 3 and the response kind in bits [1:0]. An accepted write raises `frm_valid` one cycle later and sets present bit 0 (CMD inhibit) in the same cycle. `frm_valid` stays high with a stable index and argument until `frm_ready` is seen.
- R3: A kind 00 command completes in the cycle after the frame is accepted. At that point it sets status bit 0 (command done) and clears present bit 0.
- R4: With kind 10, the response is a frame whose last 46 bits sit in `rsp_frame[45:0]`. The index is in [45:40], the 32-bit payload in [39:8], and the CRC and end bits in [7:0]. The payload is stored in response bits [31:0], and all upper response bits are zero.
- R5: With kind 01, `rsp_frame[127:0]` carries the 120-bit payload above the 8-bit CRC byte. It is stored shifted down by 8, so response bits [119:0] hold the payload and bits [127:120] are zero.
- R6: If no response arrives within TMO_TICKS asserted `rsp_tick` cycles after the frame is accepted, the controller does three things. It sets status bit 2 (timeout) and status bit 15 (error summary), and it clears present bits 0 and 1. One tick fewer leaves the command pending.
- R7: A command write while the required inhibit is set is ignored: no frame is raised and the pending command is unchanged. It sets status bit 5 (issue rejected) and status bit 15.
- R8: A kind 11 command without data waits for both present bit 0 and present bit 1 to be clear. Any other command waits only on present bit 0 and is accepted while present bit 1 is set.
- R9: A kind 11 command without data sets present bit 1 at issue. Present bit 1 stays set after the response until DAT[0] (present bit 20) is seen high. The release sets status bit 1 (busy end).
- R10: A command with data-present set sets present bit 1 at issue. Present bit 1 stays set until a `data_done` pulse arrives.
- R11: With its enable set, a CRC fault (`rsp_crc_err`) on a response sets status bit 3, and a mismatch between the 48-bit frame's index and the command's index sets status bit 4. Both also set status bit 15. With the enables clear, neither is flagged. The index of a 136-bit response is never checked.
- R12: Writing the status select clears exactly the status bits written as 1. Status bit 15 reads as the OR of bits 5 to 2.
- R13: The transfer-mode word keeps bit 0 (DMA), bit 1 (block count), bit 2 (auto stop command), bit 4 (read direction) and bit 5 (multi-block). Bit 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 argument, 1 transfer mode, 2 command, 3 status clear |
| wr_data | input | 32 | Write data |
| frm_valid | output | 1 | Frame request to the serializer |
| frm_ready | input | 1 | Serializer takes the frame |
| frm_index | output | 6 | Command index of the frame |
| frm_arg | output | 32 | Argument of the frame |
| rsp_tick | input | 1 | Response-clock enable for the timeout count |
| rsp_valid | input | 1 | Response frame present |
| rsp_frame | input | 128 | Response frame bits, CRC byte in [7:0] |
| rsp_crc_err | input | 1 | CRC fault reported by the line side |
| dat0 | input | 1 | DAT[0] line level |
| data_done | input | 1 | End of the data phase pulse |
| present_o | output | 32 | Present state: bit 0 CMD inhibit, bit 1 DAT inhibit, bit 20 DAT[0] |
| status_o | output | 16 | Status flags, write-1-to-clear |
| xfer_mode_o | output | 6 | Stored transfer-mode word |
| resp_o | output | 128 | Stored response without the CRC byte |

## Verification
The properties assume the serializer holds `frm_ready` meaningful only while a frame is offered. They also assume `rsp_valid` and `data_done` are single-cycle pulses that the line side raises only after a frame or a data command has been started. The stimulus respects this. It raises `rsp_valid` only once the command has left the send phase, and it pulses `data_done` only while a data command holds the DAT inhibit. The release checks assume that the DAT inhibit falls only after a high `dat0`, a `data_done` pulse, or a timeout. The bench keeps `dat0` low through every busy phase until it raises it on purpose.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [1:0] {
        RSP_NONE       = 2'b00,
        RSP_LONG       = 2'b01,
        RSP_SHORT      = 2'b10,
        RSP_SHORT_BUSY = 2'b11
    } rsp_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEND = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    localparam logic [1:0] SEL_ARG  = 2'd0;
    localparam logic [1:0] SEL_XFER = 2'd1;
    localparam logic [1:0] SEL_CMD  = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    localparam int ST_DONE     = 0;
    localparam int ST_BUSY_END = 1;
    localparam int ST_TMO      = 2;
    localparam int ST_CRC      = 3;
    localparam int ST_IDX      = 4;
    localparam int ST_REJ      = 5;
    localparam int ST_FLAGS    = 6;

    localparam int FRAME_W  = 128;
    localparam int RESP_W   = 128;
    localparam int CRC_BITS = 8;
    localparam int SHORT_W  = 32;
    localparam int IDX_W    = 6;
    localparam int IDX_LSB  = CRC_BITS + SHORT_W;

    localparam logic [5:0] XFER_KEEP = 6'b110111;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             data;
        logic             idx_chk;
        logic             crc_chk;
        rsp_kind_e        kind;
    } cmd_word_t;

endpackage

// File: rtl/sdc_issue_gate.sv
module sdc_issue_gate
    import sdc_pkg::*;
(
    input  rsp_kind_e kind,
    input  logic      data,
    input  logic      cmd_inh,
    input  logic      dat_inh,
    output logic      accept,
    output logic      uses_dat,
    output logic      busy_only
);
    // A busy command without data owns the DAT line on its own.
    assign busy_only = (kind == RSP_SHORT_BUSY) && !data;
    assign uses_dat  = data || (kind == RSP_SHORT_BUSY);
    assign accept    = !cmd_inh && !(busy_only && dat_inh);
endmodule

// File: rtl/sdc_rsp_unpack.sv
module sdc_rsp_unpack
    import sdc_pkg::*;
(
    input  logic [FRAME_W-1:0] frame,
    input  rsp_kind_e          kind,
    input  logic [IDX_W-1:0]   exp_idx,
    output logic [RESP_W-1:0]  resp,
    output logic               idx_ok
);
    logic [FRAME_W-1:0] no_crc;

    // Dropping the CRC byte moves the payload down by CRC_BITS.
    assign no_crc = frame >> CRC_BITS;

    always_comb begin
        if (kind == RSP_LONG) begin
            resp = RESP_W'(no_crc);
        end else begin
            resp = RESP_W'(no_crc[SHORT_W-1:0]);
        end
    end

    assign idx_ok = (frame[IDX_LSB +: IDX_W] == exp_idx);
endmodule

// File: rtl/sdc_cmd_issue.sv
module sdc_cmd_issue
    import sdc_pkg::*;
#(
    parameter int TMO_TICKS = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [31:0]  wr_data,
    output logic         frm_valid,
    input  logic         frm_ready,
    output logic [5:0]   frm_index,
    output logic [31:0]  frm_arg,
    input  logic         rsp_tick,
    input  logic         rsp_valid,
    input  logic [127:0] rsp_frame,
    input  logic         rsp_crc_err,
    input  logic         dat0,
    input  logic         data_done,
    output logic [31:0]  present_o,
    output logic [15:0]  status_o,
    output logic [5:0]   xfer_mode_o,
    output logic [127:0] resp_o
);
    localparam int TW = $clog2(TMO_TICKS + 1);
    localparam logic [TW-1:0] CNT_LAST = TW'(TMO_TICKS - 1);

    typedef struct packed {
        phase_e              ph;
        logic [TW-1:0]       cnt;
        logic [31:0]         arg;
        logic [5:0]          xfer;
        cmd_word_t           cmd;
        logic                cmd_inh;
        logic                dat_inh;
        logic                dat_by_data;
        logic                busy_wait;
        logic [ST_FLAGS-1:0] st;
        logic [RESP_W-1:0]   resp;
    } state_t;

    state_t    st_d, st_q;
    cmd_word_t new_cmd;
    logic      wr_cmd, accept, uses_dat, busy_only, idx_ok;
    logic [RESP_W-1:0] resp_unp;

    assign new_cmd = '{idx: wr_data[13:8], data: wr_data[5], idx_chk: wr_data[4],
                       crc_chk: wr_data[3], kind: rsp_kind_e'(wr_data[1:0])};
    assign wr_cmd  = wr_en && (wr_sel == SEL_CMD);

    sdc_issue_gate i_gate (
        .kind      (new_cmd.kind),
        .data      (new_cmd.data),
        .cmd_inh   (st_q.cmd_inh),
        .dat_inh   (st_q.dat_inh),
        .accept    (accept),
        .uses_dat  (uses_dat),
        .busy_only (busy_only)
    );

    sdc_rsp_unpack i_unpack (
        .frame   (rsp_frame),
        .kind    (st_q.cmd.kind),
        .exp_idx (st_q.cmd.idx),
        .resp    (resp_unp),
        .idx_ok  (idx_ok)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_sel == SEL_STAT) st_d.st = st_q.st & ~wr_data[ST_FLAGS-1:0];
        if (wr_en && wr_sel == SEL_ARG)  st_d.arg = wr_data;
        if (wr_en && wr_sel == SEL_XFER) st_d.xfer = wr_data[5:0] & XFER_KEEP;

        // End of the DAT-line phase.
        if (st_q.dat_inh && st_q.dat_by_data && data_done) st_d.dat_inh = 1'b0;
        if (st_q.busy_wait && dat0) begin
            st_d.busy_wait       = 1'b0;
            st_d.st[ST_BUSY_END] = 1'b1;
            if (!st_q.dat_by_data) st_d.dat_inh = 1'b0;
        end

        unique case (st_q.ph)
            PH_SEND: begin
                if (frm_ready) begin
                    if (st_q.cmd.kind == RSP_NONE) begin
                        st_d.ph          = PH_IDLE;
                        st_d.cmd_inh     = 1'b0;
                        st_d.st[ST_DONE] = 1'b1;
                    end else begin
                        st_d.ph  = PH_WAIT;
                        st_d.cnt = '0;
                    end
                end
            end
            PH_WAIT: begin
                if (rsp_valid) begin
                    st_d.ph          = PH_IDLE;
                    st_d.cmd_inh     = 1'b0;
                    st_d.st[ST_DONE] = 1'b1;
                    st_d.resp        = resp_unp;
                    if (st_q.cmd.crc_chk && rsp_crc_err) st_d.st[ST_CRC] = 1'b1;
                    if (st_q.cmd.idx_chk && st_q.cmd.kind != RSP_LONG && !idx_ok)
                        st_d.st[ST_IDX] = 1'b1;
                    if (st_q.cmd.kind == RSP_SHORT_BUSY && !st_q.cmd.data)
                        st_d.busy_wait = 1'b1;
                end else if (rsp_tick) begin
                    if (st_q.cnt == CNT_LAST) begin
                        st_d.ph         = PH_IDLE;
                        st_d.cmd_inh    = 1'b0;
                        st_d.dat_inh    = 1'b0;
                        st_d.busy_wait  = 1'b0;
                        st_d.st[ST_TMO] = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: ;
        endcase

        // Issue: CMD inhibit is set whenever the phase is not idle.
        if (wr_cmd) begin
            if (accept) begin
                st_d.cmd     = new_cmd;
                st_d.ph      = PH_SEND;
                st_d.cmd_inh = 1'b1;
                if (uses_dat) begin
                    st_d.dat_inh     = 1'b1;
                    st_d.dat_by_data = new_cmd.data;
                    if (busy_only) st_d.busy_wait = 1'b0;
                end
            end else begin
                st_d.st[ST_REJ] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cmd: '{kind: RSP_NONE, default: '0}, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign frm_valid   = (st_q.ph == PH_SEND);
    assign frm_index   = st_q.cmd.idx;
    assign frm_arg     = st_q.arg;
    assign present_o   = {11'b0, dat0, 18'b0, st_q.dat_inh, st_q.cmd_inh};
    assign status_o    = {|st_q.st[ST_REJ:ST_TMO], 9'b0, st_q.st};
    assign xfer_mode_o = st_q.xfer;
    assign resp_o      = st_q.resp;
endmodule

// File: rtl/sdc_cmd_issue_chk.sv
module sdc_cmd_issue_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic        frm_valid,
    input logic        frm_ready,
    input logic [5:0]  frm_index,
    input logic [31:0] frm_arg,
    input logic        dat0,
    input logic        data_done,
    input logic [31:0] present_o,
    input logic [15:0] status_o
);
    p_frame_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !frm_ready |=> frm_valid && $stable(frm_index) && $stable(frm_arg));

    p_frame_inhibit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> present_o[0]);

    p_cmd_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(present_o[0]) |-> (status_o[0] || status_o[2]));

    p_timeout_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[2]) |-> $past(present_o[0]));

    p_reject_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'd2 && present_o[0] |=> status_o[5]);

    p_dat_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(present_o[1]) |-> ($past(dat0) || $past(data_done) || status_o[2]));
endmodule

bind sdc_cmd_issue sdc_cmd_issue_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .frm_valid (frm_valid),
    .frm_ready (frm_ready),
    .frm_index (frm_index),
    .frm_arg   (frm_arg),
    .dat0      (dat0),
    .data_done (data_done),
    .present_o (present_o),
    .status_o  (status_o)
);

// File: tb/test_sdc_cmd_issue.sv
module test_sdc_cmd_issue;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = '0;
    logic [31:0]  wr_data = '0;
    logic         frm_valid;
    logic         frm_ready = 1'b1;
    logic [5:0]   frm_index;
    logic [31:0]  frm_arg;
    logic         rsp_tick = 1'b1;
    logic         rsp_valid = 1'b0;
    logic [127:0] rsp_frame = '0;
    logic         rsp_crc_err = 1'b0;
    logic         dat0 = 1'b0;
    logic         data_done = 1'b0;
    logic [31:0]  present_o;
    logic [15:0]  status_o;
    logic [5:0]   xfer_mode_o;
    logic [127:0] resp_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdc_cmd_issue #(.TMO_TICKS(TMO)) i_sdc_cmd_issue (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_index(frm_index),
        .frm_arg(frm_arg), .rsp_tick(rsp_tick), .rsp_valid(rsp_valid),
        .rsp_frame(rsp_frame), .rsp_crc_err(rsp_crc_err), .dat0(dat0),
        .data_done(data_done), .present_o(present_o), .status_o(status_o),
        .xfer_mode_o(xfer_mode_o), .resp_o(resp_o)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic give_rsp(input logic [127:0] frame, input logic crc_bad);
        rsp_valid = 1'b1; rsp_frame = frame; rsp_crc_err = crc_bad;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_crc_err = 1'b0;
    endtask

    function automatic logic [31:0] cmdw(input logic [5:0] idx, input logic data,
                                         input logic ichk, input logic cchk,
                                         input logic [1:0] kind);
        return {16'b0, 2'b00, idx, 2'b00, data, ichk, cchk, 1'b0, kind};
    endfunction

    function automatic logic [127:0] short_frame(input logic [5:0] idx, input logic [31:0] pay);
        return {82'b0, idx, pay, 7'h2B, 1'b1};
    endfunction

    task automatic t_reset();
        check("R1 present", 128'(present_o), 128'h0);
        check("R1 status", 128'(status_o), 128'h0);
        check("R1 frm_valid", 128'(frm_valid), 128'h0);
        check("R1 resp", resp_o, 128'h0);
    endtask

    task automatic t_xfer();
        wr(2'd1, 32'hFF);
        check("R13 mode bits kept, bit3 zero", 128'(xfer_mode_o), 128'h37);
        wr(2'd1, 32'h08);
        check("R13 bit3 alone reads zero", 128'(xfer_mode_o), 128'h0);
    endtask

    task automatic t_no_resp();
        frm_ready = 1'b0;
        wr(2'd0, 32'hA5A5_1234);
        wr(2'd2, cmdw(6'd0, 1'b0, 1'b0, 1'b0, 2'b00));
        check("R2 frm_valid raised", 128'(frm_valid), 128'h1);
        check("R2 index", 128'(frm_index), 128'h0);
        check("R2 arg", 128'(frm_arg), 128'hA5A5_1234);
        check("R2 cmd inhibit set", 128'(present_o), 128'h1);
        wr(2'd2, cmdw(6'd33, 1'b0, 1'b0, 1'b0, 2'b10));
        check("R7 pending frame unchanged", 128'(frm_index), 128'h0);
        check("R7 reject and summary", 128'(status_o), 128'h8020);
        @(negedge clk);
        check("R2 frame held", 128'({frm_valid, frm_arg}), {95'b0, 1'b1, 32'hA5A5_1234});
        frm_ready = 1'b1;
        @(negedge clk);
        check("R3 done on acceptance", 128'(status_o), 128'h8021);
        check("R3 cmd inhibit clear", 128'(present_o), 128'h0);
        wr(2'd3, 32'h0000_0020);
        check("R12 clears only written bit", 128'(status_o), 128'h0001);
        wr(2'd3, 32'h0000_0001);
        check("R12 all clear", 128'(status_o), 128'h0);
    endtask

    task automatic t_short();
        wr(2'd0, 32'h0000_0777);
        wr(2'd2, cmdw(6'd17, 1'b0, 1'b1, 1'b1, 2'b10));
        @(negedge clk);
        check("R4 still pending", 128'(present_o), 128'h1);
        give_rsp(short_frame(6'd17, 32'hDEAD_BEEF), 1'b0);
        check("R4 short payload", resp_o, 128'hDEAD_BEEF);
        check("R11 no error when matching", 128'(status_o), 128'h0001);
        wr(2'd3, 32'hFFFF);
    endtask

    task automatic t_long();
        logic [119:0] pay = 120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32;
        wr(2'd2, cmdw(6'd2, 1'b0, 1'b1, 1'b0, 2'b01));
        @(negedge clk);
        give_rsp({pay, 8'hFF}, 1'b0);
        check("R5 long payload shifted", resp_o, {8'h00, pay});
        check("R11 long index not checked", 128'(status_o), 128'h0001);
        wr(2'd3, 32'hFFFF);
    endtask

    task automatic t_checks();
        wr(2'd2, cmdw(6'd13, 1'b0, 1'b1, 1'b1, 2'b10));
        @(negedge clk);
        give_rsp(short_frame(6'd12, 32'h1), 1'b1);
        check("R11 crc and index errors", 128'(status_o), 128'h8019);
        wr(2'd3, 32'hFFFF);
        wr(2'd2, cmdw(6'd13, 1'b0, 1'b0, 1'b0, 2'b10));
        @(negedge clk);
        give_rsp(short_frame(6'd12, 32'h1), 1'b1);
        check("R11 checks disabled", 128'(status_o), 128'h0001);
        wr(2'd3, 32'hFFFF);
    endtask

    task automatic t_timeout();
        wr(2'd2, cmdw(6'd5, 1'b0, 1'b0, 1'b0, 2'b10));
        @(negedge clk);
        repeat (TMO - 1) @(negedge clk);
        check("R6 one tick short", 128'({status_o, present_o}), 128'h0000_0000_0000_0001);
        @(negedge clk);
        check("R6 timeout flags", 128'(status_o), 128'h8004);
        check("R6 inhibit released", 128'(present_o), 128'h0);
        wr(2'd3, 32'hFFFF);
    endtask

    task automatic t_busy();
        dat0 = 1'b0;
        wr(2'd2, cmdw(6'd7, 1'b0, 1'b0, 1'b0, 2'b11));
        check("R9 both inhibits at issue", 128'(present_o), 128'h3);
        @(negedge clk);
        give_rsp(short_frame(6'd7, 32'h900), 1'b0);
        check("R9 DAT inhibit holds while busy", 128'(present_o), 128'h2);
        wr(2'd3, 32'hFFFF);
        wr(2'd2, cmdw(6'd6, 1'b0, 1'b0, 1'b0, 2'b11));
        check("R8 busy command rejected on DAT", 128'({frm_valid, status_o}), 128'h0_8020);
        wr(2'd3, 32'hFFFF);
        wr(2'd2, cmdw(6'd9, 1'b0, 1'b0, 1'b0, 2'b10));
        check("R8 plain command accepted", 128'({frm_valid, present_o}), {95'b0, 1'b1, 32'h3});
        @(negedge clk);
        give_rsp(short_frame(6'd9, 32'h5), 1'b0);
        check("R9 still busy", 128'(present_o), 128'h2);
        wr(2'd3, 32'hFFFF);
        dat0 = 1'b1;
        @(negedge clk);
        check("R9 busy released", 128'(present_o), 128'h10_0000);
        check("R9 busy end flag", 128'(status_o), 128'h0002);
        wr(2'd3, 32'hFFFF);
    endtask

    task automatic t_data();
        wr(2'd2, cmdw(6'd18, 1'b1, 1'b0, 1'b0, 2'b10));
        check("R10 DAT inhibit at issue", 128'(present_o), 128'h10_0003);
        @(negedge clk);
        give_rsp(short_frame(6'd18, 32'h0), 1'b0);
        @(negedge clk);
        check("R10 waits for data end", 128'(present_o), 128'h10_0002);
        data_done = 1'b1;
        @(negedge clk);
        data_done = 1'b0;
        check("R10 released by data end", 128'(present_o), 128'h10_0000);
        check("R10 no busy flag", 128'(status_o), 128'h0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_xfer();
        t_no_resp();
        t_short();
        t_long();
        t_checks();
        t_timeout();
        t_busy();
        t_data();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule